// File: doc/BRIEF.md
# Clock-Generator Configuration Register Slave (two-wire serial)

This block is a two-wire serial bus slave that keeps six 8-bit configuration bytes for a clock generator and presents all of them in parallel to the clock-control logic. The SCL and SDA lines are oversampled with the system clock. Start and stop conditions are recognised from the sampled levels. The slave pulls SDA low only through an open-drain enable, and only to acknowledge or to send read data.

There is no register pointer, so every transfer starts at byte 0. A write transfer is addressed with 0xD2. It carries a command byte and a count byte, which are acknowledged and thrown away, and then data bytes for bytes 0, 1, 2 and so on. A read transfer is addressed with 0xD3. It returns a count byte first and then the bytes in ascending order. The master may end either kind of transfer after any complete byte.

The controller has eight states:
- `ST_IDLE` waits for a start.
- `ST_ADDR` shifts in the address byte.
- `ST_ADDR_ACK` drives the address acknowledge.
- `ST_WR_BYTE` and `ST_WR_ACK` receive and acknowledge write bytes.
- `ST_RD_BYTE` and `ST_RD_ACK` send a byte and then sample the master's acknowledge.
- `ST_WAIT_STOP` keeps SDA released until the next stop or start.

The transitions are:
- A start in any state goes to `ST_ADDR`. A stop in any state goes to `ST_IDLE`.
- From `ST_ADDR`, the eighth SCL fall goes to `ST_ADDR_ACK` on a matching address and to `ST_WAIT_STOP` otherwise.
- From `ST_ADDR_ACK`, the next fall goes to `ST_RD_BYTE` or `ST_WR_BYTE`, as the R/W bit selects.
- `ST_WR_BYTE` goes to `ST_WR_ACK` on the eighth fall, and `ST_WR_ACK` returns to `ST_WR_BYTE` on the next fall.
- `ST_RD_BYTE` goes to `ST_RD_ACK` on the eighth fall.
- From `ST_RD_ACK`, the next fall goes to `ST_RD_BYTE` if the master acknowledged and to `ST_WAIT_STOP` if it did not.

Top module: `clkcfg_i2c_slave`

## Requirements
- R1: The slave acknowledges only the address bytes 0xD2 (write, R/W bit 0) and 0xD3 (read, R/W bit 1). For any other address it leaves SDA released until the next stop or start.
- R2: In a write, the first two bytes after the address (command, then count) are acknowledged and change no configuration byte.
- R3: Write data bytes go into configuration bytes 0 to 5 in ascending order, and each one is acknowledged. Configuration byte k appears on `cfg_bytes[8k+7:8k]`.
- R4: A stop after any complete byte ends the write, and configuration bytes not yet reached keep their values.
- R5: Write data bytes beyond byte 5 are acknowledged and discarded.
- R6: A read returns the count byte 6 first, then bytes 0 to 5 in order, each byte MSB first.
- R7: A read past byte 5 returns 0xFF.
- R8: Reset values are byte0 = 0x1F, byte1 = 0xFF, byte2 = 0xFF, byte3 = 0x00, byte4 = 0x00, byte5 = 0x06.
- R9: Bits 7:4 of byte 0 always read 0001. A write stores only bits 3:0 of byte 0.
- R10: A start or stop in the middle of a byte abandons that byte without storing it, and the slave returns to address reception (start) or idle (stop).
- R11: After the master does not acknowledge a read byte, the slave keeps SDA released until a stop or start.
- R12: The SDA drive enable changes only after a sampled SCL falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| cfg_bytes | output | 48 | Configuration bytes 0 to 5, byte k on bits 8k+7:8k |

## Verification
The bench drives the bus as a master against a behavioural model of the six bytes. It goes after four kinds of error:
- A write stopped after two data bytes, and a write of eight data bytes. A slave that kept a pointer wrong would corrupt bytes it never reached or wrap extra data onto byte 0.
- A transfer cut by a stop or a repeated start after a few bits. A design that stored partial bytes would change byte 0.
- A read that is not acknowledged early. A slave that did not release SDA would hold the line low on the next clock.
- A foreign address, a read past the last byte (expected 0xFF), and writes to the identification nibble. These catch a decoder that is too loose, a wrong fill value and an unprotected field.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

    parameter int unsigned BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_WAIT_STOP
    } slv_state_e;

endpackage

// File: rtl/clkcfg_line_sync.sv
module clkcfg_line_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_prev;
    logic                   sda_prev;
    logic                   scl_lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
            scl_prev <= scl_pipe[SYNC_STAGES-1];
            sda_prev <= sda_pipe[SYNC_STAGES-1];
        end
    end

    assign scl_lvl   = scl_pipe[SYNC_STAGES-1];
    assign sda_lvl   = sda_pipe[SYNC_STAGES-1];
    assign scl_rise  = scl_lvl & ~scl_prev;
    assign scl_fall  = ~scl_lvl & scl_prev;
    assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
    assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

endmodule

// File: rtl/clkcfg_regfile.sv
module clkcfg_regfile #(
    parameter int unsigned          NUM_BYTES   = 6,
    parameter logic [3:0]           ID_NIBBLE   = 4'h1,
    parameter logic [NUM_BYTES*8-1:0] RESET_VALUE = 48'h06_00_00_FF_FF_1F,
    localparam int unsigned         IDX_W       = $clog2(NUM_BYTES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic [7:0]             wr_data,
    output logic [NUM_BYTES*8-1:0] cfg_flat
);

    for (genvar k = 0; k < NUM_BYTES; k++) begin : g_byte
        logic hit;
        assign hit = wr_en && (wr_idx == IDX_W'(k));
        if (k == 0) begin : g_id
            logic [3:0] low_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)   low_q <= RESET_VALUE[3:0];
                else if (hit) low_q <= wr_data[3:0];
            end
            assign cfg_flat[7:0] = {ID_NIBBLE, low_q};
        end else begin : g_plain
            logic [7:0] byte_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)   byte_q <= RESET_VALUE[k*8 +: 8];
                else if (hit) byte_q <= wr_data;
            end
            assign cfg_flat[k*8 +: 8] = byte_q;
        end
    end

endmodule

// File: rtl/clkcfg_i2c_slave.sv
module clkcfg_i2c_slave
    import clkcfg_pkg::*;
#(
    parameter logic [6:0]             DEV_ADDR    = 7'h69,
    parameter int unsigned            NUM_BYTES   = 6,
    parameter int unsigned            HDR_BYTES   = 2,
    parameter int unsigned            SYNC_STAGES = 2,
    parameter logic [3:0]             ID_NIBBLE   = 4'h1,
    parameter logic [NUM_BYTES*8-1:0] RESET_VALUE = 48'h06_00_00_FF_FF_1F
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scl_i,
    input  logic                   sda_i,
    output logic                   sda_oe,
    output logic [NUM_BYTES*8-1:0] cfg_bytes
);

    localparam int unsigned PH_MAX = HDR_BYTES + NUM_BYTES;
    localparam int unsigned PH_W   = $clog2(PH_MAX + 1);
    localparam int unsigned IDX_W  = $clog2(NUM_BYTES);
    localparam logic [PH_W-1:0] PH_HDR  = PH_W'(HDR_BYTES);
    localparam logic [PH_W-1:0] PH_END  = PH_W'(PH_MAX);
    localparam logic [PH_W-1:0] RD_END  = PH_W'(NUM_BYTES);
    localparam logic [7:0]      RD_CNT  = 8'(NUM_BYTES);

    slv_state_e       state, state_nx;
    logic [3:0]       bit_cnt;
    logic [7:0]       shreg;
    logic [PH_W-1:0]  phase;
    logic [PH_W-1:0]  rd_idx;
    logic             nack_q;
    logic [7:0]       tx_next;
    logic             byte_done;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;

    logic sda_lvl, scl_rise, scl_fall, start_det, stop_det;

    clkcfg_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    assign byte_done = scl_fall && (bit_cnt == 4'd8);
    assign wr_en     = (state == ST_WR_BYTE) && byte_done &&
                       (phase >= PH_HDR) && (phase < PH_END);
    assign wr_idx    = IDX_W'(phase - PH_HDR);

    clkcfg_regfile #(
        .NUM_BYTES   (NUM_BYTES),
        .ID_NIBBLE   (ID_NIBBLE),
        .RESET_VALUE (RESET_VALUE)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (shreg),
        .cfg_flat (cfg_bytes)
    );

    // read byte selection, 0xFF past the last byte
    always_comb begin
        tx_next = 8'hFF;
        for (int k = 0; k < NUM_BYTES; k++) begin
            if (rd_idx == PH_W'(k)) tx_next = cfg_bytes[k*8 +: 8];
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        if (start_det) begin
            state_nx = ST_ADDR;
        end else if (stop_det) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:      state_nx = ST_IDLE;
                ST_ADDR:      if (byte_done)
                                  state_nx = (shreg[7:1] == DEV_ADDR) ? ST_ADDR_ACK : ST_WAIT_STOP;
                ST_ADDR_ACK:  if (scl_fall)
                                  state_nx = shreg[0] ? ST_RD_BYTE : ST_WR_BYTE;
                ST_WR_BYTE:   if (byte_done) state_nx = ST_WR_ACK;
                ST_WR_ACK:    if (scl_fall)  state_nx = ST_WR_BYTE;
                ST_RD_BYTE:   if (scl_fall && bit_cnt == 4'd7) state_nx = ST_RD_ACK;
                ST_RD_ACK:    if (scl_fall)
                                  state_nx = nack_q ? ST_WAIT_STOP : ST_RD_BYTE;
                ST_WAIT_STOP: state_nx = ST_WAIT_STOP;
                default:      state_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
            phase   <= '0;
            rd_idx  <= '0;
            nack_q  <= 1'b0;
        end else if (start_det || stop_det) begin
            bit_cnt <= '0;
        end else begin
            unique case (state)
                ST_ADDR, ST_WR_BYTE: begin
                    if (scl_rise && bit_cnt != 4'd8) begin
                        shreg   <= {shreg[6:0], sda_lvl};
                        bit_cnt <= bit_cnt + 4'd1;
                    end else if (byte_done) begin
                        bit_cnt <= '0;
                        if (state == ST_WR_BYTE && phase != PH_END)
                            phase <= phase + 1'b1;
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        phase   <= '0;
                        rd_idx  <= '0;
                        if (shreg[0]) shreg <= RD_CNT;
                    end
                end
                ST_RD_BYTE: begin
                    if (scl_fall) begin
                        shreg   <= {shreg[6:0], 1'b1};
                        bit_cnt <= bit_cnt + 4'd1;
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) nack_q <= sda_lvl;
                    if (scl_fall) begin
                        shreg   <= tx_next;
                        bit_cnt <= '0;
                        if (rd_idx != RD_END) rd_idx <= rd_idx + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // output decode
    always_comb begin
        unique case (state)
            ST_ADDR_ACK, ST_WR_ACK: sda_oe = 1'b1;
            ST_RD_BYTE:             sda_oe = ~shreg[7];
            default:                sda_oe = 1'b0;
        endcase
    end

endmodule

// File: rtl/clkcfg_i2c_slave_chk.sv
module clkcfg_i2c_slave_chk
    import clkcfg_pkg::*;
#(
    parameter int unsigned NUM_BYTES = 6
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   scl_fall,
    input logic                   stop_det,
    input logic                   sda_oe,
    input slv_state_e             state,
    input logic [NUM_BYTES*8-1:0] cfg_bytes
);

    logic [NUM_BYTES*8-1:0] cfg_q;
    logic [NUM_BYTES-1:0]   byte_chg;

    always_ff @(posedge clk) cfg_q <= cfg_bytes;

    for (genvar k = 0; k < NUM_BYTES; k++) begin : g_chg
        assign byte_chg[k] = (cfg_bytes[k*8 +: 8] != cfg_q[k*8 +: 8]);
    end

    // R8
    reset_value_chk: assert property (@(posedge clk)
        !rst_n |=> cfg_bytes == 48'h06_00_00_FF_FF_1F);

    // R9
    id_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_bytes[7:4] == 4'b0001);

    // R3
    single_byte_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_chg != '0) |-> ($countones(byte_chg) == 1 && $past(state) == ST_WR_BYTE));

    // R11
    wait_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_WAIT_STOP |-> !sda_oe);

    // R10
    stop_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> state == ST_IDLE);

    // R12
    oe_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(sda_oe) |-> $past(scl_fall));

endmodule

bind clkcfg_i2c_slave clkcfg_i2c_slave_chk #(.NUM_BYTES(NUM_BYTES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_fall  (scl_fall),
    .stop_det  (stop_det),
    .sda_oe    (sda_oe),
    .state     (state),
    .cfg_bytes (cfg_bytes)
);

// File: tb/clkcfg_i2c_slave_tb.sv
`timescale 1ns/1ps
module clkcfg_i2c_slave_tb;

    localparam int Q = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_oe;
    logic [47:0] cfg_bytes;
    wire         sda_bus = sda_m & ~sda_oe;

    int checks = 0;
    int fails  = 0;
    int scl_hi = 0;
    bit done   = 0;
    int model [6];

    always #5 clk = ~clk;

    clkcfg_i2c_slave u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_m),
        .sda_i     (sda_bus),
        .sda_oe    (sda_oe),
        .cfg_bytes (cfg_bytes)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // R3 R4 reference model compared every clock while SCL has settled high
    always @(posedge clk) scl_hi <= scl_m ? scl_hi + 1 : 0;
    always @(negedge clk) begin
        if (rst_n && scl_hi >= 4) begin
            for (int k = 0; k < 6; k++)
                if (cfg_bytes[k*8 +: 8] != 8'(model[k]))
                    chk(0, "R3/R4 model", int'(cfg_bytes[k*8 +: 8]), model[k]);
        end
    end

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(2*Q);
    endtask

    task automatic send_bit(input bit b);
        sda_m = b; wq(Q); scl_m = 1'b1; wq(2*Q); scl_m = 1'b0; wq(Q);
    endtask

    task automatic recv_bit(output bit b);
        sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); b = sda_bus; wq(Q); scl_m = 1'b0; wq(Q);
    endtask

    // slot: configuration byte the data lands in, -1 for none
    task automatic write_byte(input logic [7:0] d, input int slot, output bit ack);
        bit r;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        if (slot >= 0 && slot < 6) model[slot] = (slot == 0) ? {4'h1, d[3:0]} : int'(d);
        recv_bit(r);
        ack = !r;
    endtask

    task automatic read_byte(input bit nack, output logic [7:0] d);
        bit b;
        for (int i = 7; i >= 0; i--) begin recv_bit(b); d[i] = b; end
        send_bit(nack);
    endtask

    task automatic wr_header();
        bit a;
        bus_start();
        write_byte(8'hD2, -1, a); chk(a, "R1 write address ack", a, 1);
        write_byte(8'h5C, -1, a); chk(a, "R2 command ack", a, 1);
        write_byte(8'h3E, -1, a); chk(a, "R2 count ack", a, 1);
    endtask

    initial begin
        logic [7:0] d;
        bit a;
        model = '{32'h1F, 32'hFF, 32'hFF, 32'h00, 32'h00, 32'h06};
        wq(5); rst_n = 1'b1; wq(10);

        // R8 reset values
        for (int k = 0; k < 6; k++)
            chk(cfg_bytes[k*8 +: 8] == 8'(model[k]), "R8 reset value",
                int'(cfg_bytes[k*8 +: 8]), model[k]);
        chk(sda_oe == 1'b0, "R8 idle release", int'(sda_oe), 0);

        // R2 header only, then stop: nothing changes
        wr_header(); bus_stop();
        chk(cfg_bytes == 48'h06_00_00_FF_FF_1F, "R2 header discarded", 0, 0);

        // R3 R9 full write
        wr_header();
        write_byte(8'hAB, 0, a); chk(a, "R3 data ack", a, 1);
        write_byte(8'h11, 1, a); chk(a, "R3 data ack", a, 1);
        write_byte(8'h22, 2, a);
        write_byte(8'h33, 3, a);
        write_byte(8'h44, 4, a);
        write_byte(8'h55, 5, a); chk(a, "R3 last data ack", a, 1);
        bus_stop();
        chk(cfg_bytes[7:0] == 8'h1B, "R9 id nibble kept", int'(cfg_bytes[7:0]), 8'h1B);
        chk(cfg_bytes[47:40] == 8'h55, "R3 byte5", int'(cfg_bytes[47:40]), 8'h55);

        // R4 partial write
        wr_header();
        write_byte(8'h07, 0, a);
        write_byte(8'hC4, 1, a);
        bus_stop();
        chk(cfg_bytes[23:16] == 8'h22, "R4 byte2 untouched", int'(cfg_bytes[23:16]), 8'h22);
        chk(cfg_bytes[15:0] == 16'hC417, "R4 bytes0-1", int'(cfg_bytes[15:0]), 16'hC417);

        // R5 overflow writes
        wr_header();
        for (int k = 0; k < 6; k++) write_byte(8'(8'h60 + k), k, a);
        write_byte(8'hEE, 6, a); chk(a, "R5 extra byte ack", a, 1);
        write_byte(8'hDD, 7, a); chk(a, "R5 extra byte ack", a, 1);
        bus_stop();
        chk(cfg_bytes[7:0] == 8'h10, "R5 byte0 not overwritten", int'(cfg_bytes[7:0]), 8'h10);

        // R1 foreign address
        bus_start();
        write_byte(8'hA0, -1, a); chk(!a, "R1 foreign address no ack", a, 0);
        write_byte(8'h99, -1, a); chk(!a, "R1 ignored after foreign address", a, 0);
        bus_stop();
        chk(cfg_bytes[15:8] == 8'h61, "R1 no change", int'(cfg_bytes[15:8]), 8'h61);

        // R6 R7 full read
        bus_start();
        write_byte(8'hD3, -1, a); chk(a, "R1 read address ack", a, 1);
        read_byte(1'b0, d); chk(d == 8'd6, "R6 count byte", d, 6);
        for (int k = 0; k < 6; k++) begin
            read_byte(1'b0, d);
            chk(d == 8'(model[k]), "R6 read data", d, model[k]);
        end
        read_byte(1'b0, d); chk(d == 8'hFF, "R7 past end", d, 8'hFF);
        read_byte(1'b1, d); chk(d == 8'hFF, "R7 past end again", d, 8'hFF);
        bus_stop();

        // R11 early NACK releases SDA
        bus_start();
        write_byte(8'hD3, -1, a);
        read_byte(1'b0, d);
        read_byte(1'b1, d); chk(d == 8'h10, "R11 byte0 before nack", d, 8'h10);
        for (int i = 0; i < 3; i++) begin
            recv_bit(a); chk(a == 1'b1, "R11 SDA released", a, 1);
        end
        bus_stop();

        // R10 stop mid-byte
        wr_header();
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        bus_stop();
        chk(cfg_bytes[7:0] == 8'h10, "R10 stop abort", int'(cfg_bytes[7:0]), 8'h10);

        // R10 start mid-byte, then a clean transfer
        wr_header();
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        bus_start();
        write_byte(8'hD2, -1, a); chk(a, "R10 restart address ack", a, 1);
        write_byte(8'h00, -1, a);
        write_byte(8'h00, -1, a);
        write_byte(8'hFA, 0, a);
        bus_stop();
        chk(cfg_bytes[7:0] == 8'h1A, "R10 restart write", int'(cfg_bytes[7:0]), 8'h1A);
        chk(cfg_bytes[15:8] == 8'h61, "R10 byte1 kept", int'(cfg_bytes[15:8]), 8'h61);

        wq(20);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule